// File: doc/BRIEF.md
# Bus-Snooping Serial Register Unlock

This block sits on an asynchronous SRAM-style bus and watches the chip enable, output enable, write enable and data bit 0 lines. It looks for a fixed 64-bit key. The key arrives one bit per write cycle on data bit 0. The attempt starts when a read cycle sets a pointer to the first key bit. Each matching write moves the pointer forward. A mismatch freezes the pointer, and later writes are ignored until the next read restarts the search. A read at any point aborts an attempt that is in progress.

When all 64 key bits have matched, the block owns the next 64 bus cycles and blocks the memory for those cycles. A read cycle drives the next bit of a 64-bit register image out on data bit 0. A write cycle shifts the bus bit in. Bits move least significant first, from image bit 0 up to bit 63. If any write cycle occurred in the window, the assembled word is written back as one parallel store after the last cycle. The bus strobes are synchronised to the system clock, and a cycle is recognised on the synchronised assertion edge of its strobe combination.

Top module: `bus_key_unlock`

## Requirements
- R1: After reset no recognition attempt is armed. Write cycles (ce_ni=0, we_ni=0) do not advance matching until a read cycle (ce_ni=0, oe_ni=0, we_ni=1) has been seen, so writing the full key right after reset leaves unlocked_o low.
- R2: A read cycle outside the transfer window resets the pointer to key bit 0 and arms a new attempt. A read partway through the key aborts the progress made so far.
- R3: While armed, each write cycle compares dq0_i with KEY[ptr], starting at bit 0. A match advances the pointer. The 64th consecutive match raises unlocked_o and mem_inhibit_o.
- R4: A mismatching write stalls the attempt. All later writes, including a complete correct key, are ignored until a read cycle re-arms.
- R5: mem_inhibit_o stays low during every recognition write, including the first 63 matching ones. It rises only after the 64th matching write.
- R6: unlocked_o stays high for exactly 64 bus cycles after the match and then returns low. A new read and key are needed to unlock again.
- R7: The k-th transfer cycle (k counted from 0), if it is a read, drives reg_img_i[k] on dq0_o with dq0_oe_o high. dq0_oe_o is low during write cycles and outside the window.
- R8: The k-th transfer cycle, if it is a write, places dq0_i at bit k of the stored word. After the 64th cycle, reg_wr_en_o pulses once with the word on reg_wr_data_o. A window that contains only reads produces no pulse.
- R9: mem_inhibit_o stays high through the 64th transfer cycle and falls once the bus strobes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Bus chip enable, active low, asynchronous |
| oe_ni | input | 1 | Bus output enable, active low, asynchronous |
| we_ni | input | 1 | Bus write enable, active low, asynchronous |
| dq0_i | input | 1 | Bus data bit 0 as driven by the host |
| reg_img_i | input | 64 | Current register image to be read out |
| unlocked_o | output | 1 | High while the 64-cycle transfer window is open |
| mem_inhibit_o | output | 1 | Blocks the memory array for the transfer cycles |
| dq0_o | output | 1 | Serial data bit driven during transfer reads |
| dq0_oe_o | output | 1 | Drive enable for dq0_o |
| reg_wr_en_o | output | 1 | One-cycle pulse that stores the shifted-in word |
| reg_wr_data_o | output | 64 | Word to be stored |

## Verification
A pointer that has wrongly advanced or failed to reset shows up at the ports after a bounded number of bus cycles. The window opens early or never, and mem_inhibit_o or unlocked_o changes within about three clocks of the write that should or should not complete the key. A miscounted or misordered transfer shows up as a wrong bit on dq0_o during the affected read. It can also appear as a wrong or missing reg_wr_en_o pulse one clock after the 64th cycle, or as the window closing at the wrong cycle. The stall and abort paths are checked by letting the whole correct key follow and confirming that the window stays closed.

// File: rtl/bku_pkg.sv
package bku_pkg;
  localparam int unsigned IMG_W  = 64;
  localparam int unsigned SYNC_N = 2;
  typedef struct packed {
    logic rd_lvl;
    logic wr_lvl;
    logic rd_evt;
    logic wr_evt;
    logic bit_v;
  } bus_evt_t;
endpackage

// File: rtl/bku_strobe_sync.sv
module bku_strobe_sync
  import bku_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_N
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ce_ni,
  input  logic     oe_ni,
  input  logic     we_ni,
  input  logic     dq0_i,
  output bus_evt_t evt_o
);
  // {ce, oe, we, dq}
  logic [3:0] pipe_q [STAGES];
  logic [3:0] s;
  logic       rd_q, wr_q, rd_l, wr_l;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) pipe_q[i] <= 4'b1110;
    end else begin
      pipe_q[0] <= {ce_ni, oe_ni, we_ni, dq0_i};
      for (int i = 1; i < int'(STAGES); i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign s    = pipe_q[STAGES-1];
  assign rd_l = !s[3] && !s[2] && s[1];
  assign wr_l = !s[3] && !s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_l;
      wr_q <= wr_l;
    end
  end

  assign evt_o.rd_lvl = rd_l;
  assign evt_o.wr_lvl = wr_l;
  assign evt_o.rd_evt = rd_l && !rd_q;
  assign evt_o.wr_evt = wr_l && !wr_q;
  assign evt_o.bit_v  = s[0];
endmodule

// File: rtl/bku_key_matcher.sv
module bku_key_matcher
  import bku_pkg::*;
#(
  parameter int unsigned   KEY_W = IMG_W,
  parameter logic [KEY_W-1:0] KEY = '0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hunt_i,
  input  bus_evt_t evt_i,
  output logic     hit_o
);
  localparam int unsigned PTR_W = $clog2(KEY_W);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_W - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             armed_q;
  logic             match;

  assign match = (evt_i.bit_v == KEY[ptr_q]);
  assign hit_o = hunt_i && armed_q && evt_i.wr_evt && match && (ptr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
    end else if (hunt_i) begin
      if (evt_i.rd_evt) begin
        ptr_q   <= '0;
        armed_q <= 1'b1;
      end else if (evt_i.wr_evt && armed_q) begin
        if (!match) begin
          armed_q <= 1'b0;
        end else if (ptr_q == LAST) begin
          ptr_q   <= '0;
          armed_q <= 1'b0;
        end else begin
          ptr_q <= ptr_q + PTR_W'(1);
        end
      end
    end
  end

  // R2: read re-arms at bit 0
  a_r2_read_rearms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_i && evt_i.rd_evt |=> armed_q && ptr_q == '0);
  // R4: a stalled attempt does not move
  a_r4_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_i && !armed_q && !evt_i.rd_evt |=> !armed_q && $stable(ptr_q));
endmodule

// File: rtl/bku_xfer_engine.sv
module bku_xfer_engine
  import bku_pkg::*;
#(
  parameter int unsigned W = IMG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  bus_evt_t     evt_i,
  input  logic [W-1:0] img_i,
  output logic         active_o,
  output logic         inhibit_o,
  output logic         dout_o,
  output logic         doe_o,
  output logic         wr_en_o,
  output logic [W-1:0] wr_data_o
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             active_q, tail_q, seen_wr_q, dout_q, wr_en_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     sh_q;
  logic             evt;

  assign evt = active_q && (evt_i.rd_evt || evt_i.wr_evt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      tail_q    <= 1'b0;
      seen_wr_q <= 1'b0;
      dout_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        active_q  <= 1'b1;
        cnt_q     <= '0;
        sh_q      <= img_i;
        seen_wr_q <= 1'b0;
      end else if (evt) begin
        if (evt_i.wr_evt) begin
          sh_q      <= {evt_i.bit_v, sh_q[W-1:1]};
          seen_wr_q <= 1'b1;
        end else begin
          dout_q <= sh_q[0];
          sh_q   <= {sh_q[0], sh_q[W-1:1]};
        end
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          tail_q   <= 1'b1;
          wr_en_q  <= seen_wr_q || evt_i.wr_evt;
        end
      end else if (tail_q && !evt_i.rd_lvl && !evt_i.wr_lvl) begin
        tail_q <= 1'b0;
      end
    end
  end

  assign active_o  = active_q;
  assign inhibit_o = active_q || tail_q;
  assign dout_o    = dout_q;
  assign doe_o     = (active_q || tail_q) && evt_i.rd_lvl;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = sh_q;

  // R6: window opens only on a key hit
  a_r6_open_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(start_i));
  // R8: store pulse only right after the window closes
  a_r8_commit_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> !active_q && $past(active_q));
  // R7: driven bit held between cycles
  a_r7_dout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt |=> $stable(dout_q));
endmodule

// File: rtl/bus_key_unlock.sv
module bus_key_unlock
  import bku_pkg::*;
#(
  parameter int unsigned      W   = IMG_W,
  parameter logic [W-1:0]     KEY = 64'hC5A3_96E1_0FF0_3C5A
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         oe_ni,
  input  logic         we_ni,
  input  logic         dq0_i,
  input  logic [W-1:0] reg_img_i,
  output logic         unlocked_o,
  output logic         mem_inhibit_o,
  output logic         dq0_o,
  output logic         dq0_oe_o,
  output logic         reg_wr_en_o,
  output logic [W-1:0] reg_wr_data_o
);
  bus_evt_t evt;
  logic     hit, inhibit;

  bku_strobe_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .dq0_i, .evt_o(evt)
  );

  bku_key_matcher #(.KEY_W(W), .KEY(KEY)) u_match (
    .clk_i, .rst_ni, .hunt_i(!inhibit), .evt_i(evt), .hit_o(hit)
  );

  bku_xfer_engine #(.W(W)) u_xfer (
    .clk_i, .rst_ni, .start_i(hit), .evt_i(evt), .img_i(reg_img_i),
    .active_o(unlocked_o), .inhibit_o(inhibit), .dout_o(dq0_o),
    .doe_o(dq0_oe_o), .wr_en_o(reg_wr_en_o), .wr_data_o(reg_wr_data_o)
  );

  assign mem_inhibit_o = inhibit;

  // R5: memory blocked only after a full key match
  a_r5_inhibit_after_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_inhibit_o) |-> $past(hit));
  // R7: never drive during a write strobe
  a_r7_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt.wr_lvl |-> !dq0_oe_o);
endmodule

// File: tb/sim_bus_key_unlock.sv
module sim_bus_key_unlock;
  localparam logic [63:0] KEY = 64'hC5A3_96E1_0FF0_3C5A;
  localparam logic [63:0] IMG = 64'h1234_5678_9ABC_DEF0;
  localparam logic [63:0] WPAT = 64'hF00D_CAFE_0BAD_BEEF;

  logic clk = 0, rst_ni = 0;
  logic ce_ni = 1, oe_ni = 1, we_ni = 1, dq0_i = 0;
  logic unlocked_o, mem_inhibit_o, dq0_o, dq0_oe_o, reg_wr_en_o;
  logic [63:0] reg_wr_data_o;
  int tests = 0, fails = 0, commits = 0;
  logic [63:0] last_commit = '0;
  bit exp_q[$];
  string tag_q[$];
  event sample_ev;
  logic smp_bit, smp_oe;

  always #2 clk = ~clk;

  bus_key_unlock #(.KEY(KEY)) u0 (
    .clk_i(clk), .rst_ni, .ce_ni, .oe_ni, .we_ni, .dq0_i,
    .reg_img_i(IMG), .unlocked_o, .mem_inhibit_o, .dq0_o, .dq0_oe_o,
    .reg_wr_en_o, .reg_wr_data_o
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: compare driven read bits against the scoreboard
  initial forever begin
    @(sample_ev);
    if (exp_q.size() == 0) check(0, "R7 unexpected read sample", 64'(smp_bit), 0);
    else begin
      automatic bit e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(smp_bit == e && smp_oe, t, {62'd0, smp_oe, smp_bit}, {62'd0, 1'b1, e});
    end
  end

  always @(negedge clk) if (reg_wr_en_o) begin
    commits++;
    last_commit = reg_wr_data_o;
  end

  logic inh_seen, oe_seen;

  task automatic bus_cycle(input bit is_wr, input bit b, input bit sample);
    @(negedge clk);
    dq0_i = b; ce_ni = 0;
    if (is_wr) we_ni = 0; else oe_ni = 0;
    repeat (6) @(negedge clk);
    smp_bit = dq0_o; smp_oe = dq0_oe_o;
    inh_seen = mem_inhibit_o; oe_seen = dq0_oe_o;
    if (sample) -> sample_ev;
    ce_ni = 1; we_ni = 1; oe_ni = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_key(input logic [63:0] k, input int from, input int upto, output bit inh_any);
    inh_any = 0;
    for (int i = from; i < upto; i++) begin
      bus_cycle(1, k[i], 0);
      if (inh_seen) inh_any = 1;
    end
  endtask

  task automatic read_window(input logic [63:0] img, input string tag, output bit last_inh);
    for (int i = 0; i < 64; i++) begin
      exp_q.push_back(img[i]);
      tag_q.push_back(tag);
      bus_cycle(0, 0, 1);
    end
    last_inh = inh_seen;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R6 act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ia, li, oe_any;
    logic [63:0] k2;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    check(!unlocked_o && !mem_inhibit_o && !dq0_oe_o && !reg_wr_en_o, "R1 reset outputs",
          {unlocked_o, mem_inhibit_o, dq0_oe_o, reg_wr_en_o}, 0);

    // R1: key without prior read
    send_key(KEY, 0, 64, ia);
    check(!unlocked_o, "R1 key without read", unlocked_o, 0);

    // R3/R5: read then key, inhibit low throughout
    bus_cycle(0, 0, 0);
    send_key(KEY, 0, 63, ia);
    check(!ia && !mem_inhibit_o, "R5 inhibit during 63 matches", {ia, mem_inhibit_o}, 0);
    check(!unlocked_o, "R3 not unlocked at 63", unlocked_o, 0);
    send_key(KEY, 63, 64, ia);
    repeat (2) @(negedge clk);
    check(unlocked_o && mem_inhibit_o, "R3 unlock after 64th", {unlocked_o, mem_inhibit_o}, 2'b11);

    // R7: read-out LSB first
    read_window(IMG, "R7 readout bit", li);
    check(li, "R9 inhibit on 64th cycle", li, 1);
    check(!unlocked_o && !mem_inhibit_o, "R6/R9 closed after 64", {unlocked_o, mem_inhibit_o}, 0);
    check(commits == 0, "R8 no store for read window", commits, 0);

    // R8: write-in
    bus_cycle(0, 0, 0);
    send_key(KEY, 0, 64, ia);
    oe_any = 0;
    for (int i = 0; i < 64; i++) begin
      bus_cycle(1, WPAT[i], 0);
      if (oe_seen) oe_any = 1;
    end
    repeat (3) @(negedge clk);
    check(commits == 1, "R8 single store pulse", commits, 1);
    check(last_commit == WPAT, "R8 stored word", last_commit, WPAT);
    check(!oe_any, "R7 no drive on writes", oe_any, 0);
    check(!unlocked_o, "R6 closed after write window", unlocked_o, 0);

    // R4: one wrong bit stalls
    k2 = KEY; k2[10] = ~k2[10];
    bus_cycle(0, 0, 0);
    send_key(k2, 0, 64, ia);
    check(!unlocked_o && !ia, "R4 wrong bit stalls", {unlocked_o, ia}, 0);
    send_key(KEY, 0, 64, ia);
    check(!unlocked_o, "R4 full key ignored after stall", unlocked_o, 0);
    bus_cycle(0, 0, 0);
    send_key(KEY, 0, 64, ia);
    repeat (2) @(negedge clk);
    check(unlocked_o, "R2 read restarts after stall", unlocked_o, 1);
    read_window(IMG, "R7 readout after restart", li);

    // R2: read inserted partway aborts
    bus_cycle(0, 0, 0);
    send_key(KEY, 0, 30, ia);
    bus_cycle(0, 0, 0);
    send_key(KEY, 30, 64, ia);
    check(!unlocked_o && !mem_inhibit_o, "R2 read aborts attempt", {unlocked_o, mem_inhibit_o}, 0);
    bus_cycle(0, 0, 0);
    send_key(KEY, 0, 64, ia);
    repeat (2) @(negedge clk);
    check(unlocked_o, "R2 fresh attempt unlocks", unlocked_o, 1);
    read_window(IMG, "R7 readout final", li);
    check(!unlocked_o, "R6 closed final", unlocked_o, 0);
    check(commits == 1, "R8 no extra store", commits, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule